// File: doc/BRIEF.md
# Mixed-Width Widening Multiply-Accumulate Lane

This block is one arithmetic lane of a vector datapath. On every cycle that its input is qualified as valid, it multiplies a narrow 8-bit element by a 16-bit element and adds the product to a 32-bit accumulator element. The sum comes out, with a matching valid flag, one clock later. The two multiplier inputs are only read. The single result goes back to the destination element through the surrounding datapath.

A 2-bit mode input sets how each multiplier operand is read:
- `2'b00`: both operands are two's complement.
- `2'b01`: the 8-bit operand is two's complement and the 16-bit operand is unsigned.
- `2'b10`: both operands are unsigned.
- `2'b11`: reserved; it acts exactly like `2'b10`.

The product is widened to 32 bits before the add: sign-extended when signed, zero-extended when unsigned. The add wraps modulo 2^32. Saturation, element sequencing and instruction decode belong to neighbouring logic.

Top module: `wmac_lane`

## Requirements
- R1: `res_valid` is high in the cycle after a rising clock edge at which `op_valid` was high, and low after an edge at which `op_valid` was low.
- R2: While `rst` is high at a rising edge, the lane clears `res_valid` and `res_acc` to zero on that edge. Both stay zero until the next valid operation.
- R3: With `mode` = 2'b00, `res_acc` = `acc_in` + (signed `src_n` × signed `src_w`) mod 2^32. A negative product is sign-extended through bit 31.
- R4: With `mode` = 2'b01, `src_n` is read as signed and `src_w` as unsigned (0..65535), and the same sum is formed.
- R5: With `mode` = 2'b10, both operands are read as unsigned and the product is zero-extended before the add.
- R6: `mode` = 2'b11 gives the same result as `mode` = 2'b10 for every operand pair.
- R7: The 32-bit add wraps modulo 2^32 in both directions, with no saturation and no flag.
- R8: After an edge at which `op_valid` was low, `res_acc` keeps its previous value, whatever `mode`, `src_n`, `src_w` and `acc_in` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Qualifies the operands for this cycle |
| mode | input | 2 | Signedness select: 00 s×s, 01 s×u, 10 u×u, 11 as 10 |
| src_n | input | 8 | Narrow multiplier operand |
| src_w | input | 16 | Wide multiplier operand |
| acc_in | input | 32 | Accumulator element to add to |
| res_valid | output | 1 | Result qualifier, one cycle after `op_valid` |
| res_acc | output | 32 | Updated accumulator element |

## Verification
The bench sweeps every 8-bit operand against a spread of 16-bit values under all four modes. The 16-bit values include 0x7FFF, 0x8000 and 0xFFFF, so a lane that sign-extended an unsigned operand, or zero-extended a signed one, gives a sum that is off by a multiple of 2^8 or 2^16.

Accumulators close to 0 and close to 2^32 catch two further faults:
- a product that is zero-extended when it should be sign-extended;
- an adder that saturates or drops the carry.

Idle cycles carry garbage operands, which exposes a result register that loads without qualification. Reset is also applied in the middle of a run, which shows whether the lane keeps stale data.

// File: rtl/wmac_pkg.sv
package wmac_pkg;

    localparam int unsigned N_W   = 8;
    localparam int unsigned W_W   = 16;
    localparam int unsigned ACC_W = 32;

    typedef enum logic [1:0] {
        MODE_SS  = 2'b00,
        MODE_SU  = 2'b01,
        MODE_UU  = 2'b10,
        MODE_RSV = 2'b11
    } wmac_mode_e;

    typedef struct packed {
        logic n_signed;
        logic w_signed;
    } sign_sel_t;

    // Reserved encoding folds onto unsigned x unsigned.
    function automatic sign_sel_t decode_mode(input logic [1:0] m);
        sign_sel_t s;
        unique case (wmac_mode_e'(m))
            MODE_SS:  s = '{n_signed: 1'b1, w_signed: 1'b1};
            MODE_SU:  s = '{n_signed: 1'b1, w_signed: 1'b0};
            default:  s = '{n_signed: 1'b0, w_signed: 1'b0};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/wmac_sign_ext.sv
// Widens an operand by one bit so that one signed multiplier covers both readings.
module wmac_sign_ext #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0]      din,
    input  logic              is_signed,
    output logic signed [W:0] dout
);
    assign dout = {is_signed & din[W-1], din};
endmodule

// File: rtl/wmac_mult.sv
module wmac_mult
    import wmac_pkg::*;
#(
    parameter int unsigned NW = N_W,
    parameter int unsigned WW = W_W,
    localparam int unsigned PW = NW + WW + 2
) (
    input  logic [1:0]           mode,
    input  logic [NW-1:0]        src_n,
    input  logic [WW-1:0]        src_w,
    output logic signed [PW-1:0] prod
);
    sign_sel_t sel;
    logic signed [NW:0] n_ext;
    logic signed [WW:0] w_ext;

    assign sel = decode_mode(mode);

    wmac_sign_ext #(.W(NW)) u_ext_n (.din(src_n), .is_signed(sel.n_signed), .dout(n_ext));
    wmac_sign_ext #(.W(WW)) u_ext_w (.din(src_w), .is_signed(sel.w_signed), .dout(w_ext));

    assign prod = PW'(n_ext) * PW'(w_ext);
endmodule

// File: rtl/wmac_accum.sv
module wmac_accum #(
    parameter int unsigned PW   = 26,
    parameter int unsigned AW   = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 op_valid,
    input  logic signed [PW-1:0] prod,
    input  logic [AW-1:0]        acc_in,
    output logic                 res_valid,
    output logic [AW-1:0]        res_acc,
    output logic                 hist_ok
);
    localparam int unsigned EXT = AW - PW;

    logic [AW-1:0] prod_wide;
    logic [AW-1:0] sum;

    generate
        if (EXT > 0) begin : g_extend
            assign prod_wide = {{EXT{prod[PW-1]}}, prod};
        end else begin : g_trunc
            assign prod_wide = prod[AW-1:0];
        end
    endgenerate

    assign sum = acc_in + prod_wide;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_acc   <= '0;
            hist_ok   <= 1'b0;
        end else begin
            res_valid <= op_valid;
            hist_ok   <= 1'b1;
            if (op_valid) begin
                res_acc <= sum;
            end
        end
    end

    // R1: valid flag trails the input qualifier by one clock
    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (rst)
        hist_ok |-> (res_valid == $past(op_valid)));

    // R2: a reset edge leaves the lane empty
    assert_reset_clear_R2: assert property (@(posedge clk)
        rst |=> (!res_valid && res_acc == '0));

    // R8: idle cycles do not disturb the result
    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (hist_ok && !$past(op_valid)) |-> $stable(res_acc));
endmodule

// File: rtl/wmac_lane.sv
module wmac_lane
    import wmac_pkg::*;
#(
    parameter int unsigned NW = N_W,
    parameter int unsigned WW = W_W,
    parameter int unsigned AW = ACC_W,
    localparam int unsigned PW = NW + WW + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic [1:0]    mode,
    input  logic [NW-1:0] src_n,
    input  logic [WW-1:0] src_w,
    input  logic [AW-1:0] acc_in,
    output logic          res_valid,
    output logic [AW-1:0] res_acc
);
    logic signed [PW-1:0] prod;
    logic                 hist_ok;

    wmac_mult #(.NW(NW), .WW(WW)) u_mult (
        .mode  (mode),
        .src_n (src_n),
        .src_w (src_w),
        .prod  (prod)
    );

    wmac_accum #(.PW(PW), .AW(AW)) u_accum (
        .clk       (clk),
        .rst       (rst),
        .op_valid  (op_valid),
        .prod      (prod),
        .acc_in    (acc_in),
        .res_valid (res_valid),
        .res_acc   (res_acc),
        .hist_ok   (hist_ok)
    );

    // R3: a zero narrow operand leaves the accumulator untouched
    assert_zero_operand_R3: assert property (@(posedge clk) disable iff (rst)
        (hist_ok && $past(op_valid) && $past(src_n) == '0) |-> (res_acc == $past(acc_in)));

    // R5: an unsigned product never pushes the sum more than 2^(NW+WW) above the input
    assert_uu_range_R5: assert property (@(posedge clk) disable iff (rst)
        (hist_ok && $past(op_valid) && $past(mode) == 2'b10)
        |-> ((res_acc - $past(acc_in)) < (AW'(1) << (NW + WW))));

    // R6: the reserved mode also stays within the unsigned range
    assert_rsv_range_R6: assert property (@(posedge clk) disable iff (rst)
        (hist_ok && $past(op_valid) && $past(mode) == 2'b11)
        |-> ((res_acc - $past(acc_in)) < (AW'(1) << (NW + WW))));
endmodule

// File: tb/wmac_lane_bench.sv
`timescale 1ns/1ps
module wmac_lane_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [7:0]  src_n = '0;
    logic [15:0] src_w = '0;
    logic [31:0] acc_in = '0;
    logic        res_valid;
    logic [31:0] res_acc;

    int checks = 0;
    int errors = 0;
    logic [31:0] last_acc;

    always #2.5 clk = ~clk;

    wmac_lane u_wmac_lane (
        .clk(clk), .rst(rst), .op_valid(op_valid), .mode(mode),
        .src_n(src_n), .src_w(src_w), .acc_in(acc_in),
        .res_valid(res_valid), .res_acc(res_acc)
    );

    function automatic logic [31:0] model(logic [1:0] m, logic [7:0] a, logic [15:0] b, logic [31:0] acc);
        longint va, vb, r;
        va = (m == 2'b00 || m == 2'b01) ? longint'($signed(a)) : longint'(a);
        vb = (m == 2'b00) ? longint'($signed(b)) : longint'(b);
        r  = longint'(acc) + va * vb;
        return r[31:0];
    endfunction

    function automatic logic [15:0] wpick(int i);
        case (i)
            0: return 16'h0000;  1: return 16'h0001;  2: return 16'h0002;  3: return 16'h007F;
            4: return 16'h0080;  5: return 16'h00FF;  6: return 16'h1234;  7: return 16'h7FFE;
            8: return 16'h7FFF;  9: return 16'h8000; 10: return 16'h8001; 11: return 16'hA5C3;
           12: return 16'hFF00; 13: return 16'hFFFE; 14: return 16'hFFFF; default: return 16'h4000;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_op(string tag, logic v, logic [1:0] m, logic [7:0] a, logic [15:0] b, logic [31:0] acc);
        logic [31:0] exp;
        @(negedge clk);
        op_valid = v; mode = m; src_n = a; src_w = b; acc_in = acc;
        exp = v ? model(m, a, b, acc) : last_acc;
        @(posedge clk); #1;
        check({tag, " R1 valid"}, {31'd0, res_valid}, {31'd0, v});
        check(tag, res_acc, exp);
        last_acc = exp;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; op_valid = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R2 reset valid", {31'd0, res_valid}, 32'd0);
        check("R2 reset acc", res_acc, 32'd0);
        @(negedge clk); rst = 1'b0; op_valid = 1'b0;
        @(posedge clk); #1;
        check("R2 after reset valid", {31'd0, res_valid}, 32'd0);
        check("R2 after reset acc", res_acc, 32'd0);
        last_acc = 32'd0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        last_acc = 32'd0;
        do_reset();

        // R3 sign extension of a negative product through bit 31
        run_op("R3 neg product", 1'b1, 2'b00, 8'hFF, 16'h0001, 32'd0);
        run_op("R3 min x min", 1'b1, 2'b00, 8'h80, 16'h8000, 32'd0);
        run_op("R4 neg x big unsigned", 1'b1, 2'b01, 8'h80, 16'hFFFF, 32'd0);
        run_op("R5 max x max", 1'b1, 2'b10, 8'hFF, 16'hFFFF, 32'd0);
        // R7 wrap upward and downward
        run_op("R7 wrap up", 1'b1, 2'b10, 8'hFF, 16'hFFFF, 32'hFFFF_FFF0);
        run_op("R7 wrap down", 1'b1, 2'b00, 8'h01, 16'hFFFF, 32'd0);
        run_op("R7 wrap top", 1'b1, 2'b00, 8'h7F, 16'h7FFF, 32'h7FFF_FFFF);

        // R8 idle cycles with garbage operands keep the result
        for (int i = 0; i < 4; i++) begin
            run_op("R8 idle hold", 1'b0, 2'(i), 8'hA5 ^ 8'(i), 16'h5A5A, 32'hDEAD_BEEF);
        end

        // sweep every narrow operand against chosen wide operands in each mode
        for (int m = 0; m < 4; m++) begin
            for (int a = 0; a < 256; a++) begin
                for (int bi = 0; bi < 16; bi++) begin
                    logic [31:0] acc;
                    string tag;
                    acc = (32'(a) * 32'h9E37_79B1) ^ (32'(bi) << 20) ^ 32'(m);
                    case (m)
                        0: tag = "R3 sweep s*s";
                        1: tag = "R4 sweep s*u";
                        2: tag = "R5 sweep u*u";
                        default: tag = "R6 sweep reserved";
                    endcase
                    run_op(tag, 1'b1, 2'(m), 8'(a), wpick(bi), acc);
                end
                if ((a % 64) == 0) run_op("R8 idle in sweep", 1'b0, 2'b00, 8'h33, 16'hCCCC, 32'h1);
            end
        end

        // R6 reserved matches u*u on a negative-looking pair
        run_op("R6 reserved high bits", 1'b1, 2'b11, 8'h80, 16'h8000, 32'h0000_0001);

        // R2 reset in the middle of activity
        run_op("R1 before mid reset", 1'b1, 2'b00, 8'h12, 16'h3456, 32'h1111_1111);
        do_reset();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule